// File: doc/BRIEF.md
# Round-Key Expansion Engine for a 32-bit-Word Block Cipher

This block turns a 128-bit user key into the 44 round-key words of 32 bits each that a 20-round cipher core uses. The same table serves both encryption and decryption. A one-cycle start strobe captures the key and begins the expansion. The engine first fills its internal table with a fixed arithmetic progression. It then makes three passes over the table. Each pass folds the four user-key words into the table using modular addition and data-dependent left rotations.

The engine handles one table entry per clock: 44 cycles for seeding and 132 cycles for mixing. A ready flag rises when the last mixing step has been written. From then on the cipher core reads any round key through a combinational address/data port. The table stays unchanged until the next start. A start that arrives at any time, including during an expansion, discards the work in progress and begins again with the key present on that cycle.

Top module: `rc6_keyexp`

## Requirements
- R1: After reset, `ready` is 0 and stays 0 until an expansion completes.
- R2: On the clock edge that samples `start` = 1, `user_key` is captured. `ready` reads 0 after that edge and remains 0 until the expansion finishes.
- R3: The engine processes one table entry per cycle. `ready` first reads 1 after the 176th clock edge that follows the edge sampling `start` (44 seeding edges plus 132 mixing edges).
- R4: The key is split into four words little-endian: word k is `user_key[32k+31:32k]`, so key byte n sits at bits 8n+7:8n.
- R5: Seeding writes entry t with 0xB7E15163 + t × 0x9E3779B9 (mod 2^32), for t = 0..43.
- R6: Mixing runs 132 steps, with two running values X = Y = 0 and table index t and key index k both starting at 0. Each step sets X = S[t] = rotl(S[t]+X+Y, 3), then Y = L[k] = rotl(L[k]+X+Y, (X+Y) mod 32), where L is the key word array. Then t advances modulo 44 and k advances modulo 4.
- R7: While `ready` is 1, `rk_data` equals table entry `rk_addr` in the same cycle. Addresses 44 to 63 read as 0.
- R8: A `start` sampled during seeding or mixing, including on the edge of the final mixing step, abandons that expansion. The flag stays low, and the table ends up holding the expansion of the newly captured key, 176 edges later.
- R9: While `ready` is 1 and `start` is 0, changing `user_key` has no effect on `ready` or on any table entry.
- R10: Changes on `user_key` after the start edge and during the expansion have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture key and begin expansion |
| user_key | input | 128 | User key, byte n at bits 8n+7:8n |
| rk_addr | input | 6 | Round-key read address |
| rk_data | output | 32 | Round-key read data (combinational) |
| ready | output | 1 | Round-key table complete and valid |

## Verification
The two functions that can meet in one cycle are completion and restart. The final mixing step writes its entry and would raise the flag on the same edge that a fresh start is sampled. The bench provokes this by counting edges from a first start and pulsing a second start, with a different key, exactly on the 176th edge. It then judges that the flag stays low on that edge, rises only 176 edges after the second start, and that every table word matches the second key's independently computed expansion. Restarts in mid-seeding and mid-mixing are judged the same way.

// File: rtl/rc6ke_pkg.sv
package rc6ke_pkg;

  localparam int WORD_W = 32;
  localparam logic [WORD_W-1:0] SEED_BASE = 32'hB7E15163;
  localparam logic [WORD_W-1:0] SEED_STEP = 32'h9E3779B9;
  localparam logic [4:0] FIXED_ROT = 5'd3;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEED = 2'd1,
    ST_MIX  = 2'd2,
    ST_DONE = 2'd3
  } ke_state_e;

  function automatic word_t rotl32(input word_t v, input logic [4:0] s);
    logic [5:0] rs;
    rs = 6'd32 - {1'b0, s};
    return (v << s) | (v >> rs);
  endfunction

  // table-side update of one mixing step
  function automatic word_t mix_tab(input word_t s, input word_t x, input word_t y);
    return rotl32(s + x + y, FIXED_ROT);
  endfunction

  // key-side update of one mixing step, x already updated
  function automatic word_t mix_key(input word_t l, input word_t x, input word_t y);
    word_t t;
    t = x + y;
    return rotl32(l + t, t[4:0]);
  endfunction

endpackage

// File: rtl/rc6ke_ctrl.sv
module rc6ke_ctrl
  import rc6ke_pkg::*;
#(
  parameter int NRK    = 44,
  parameter int NLW    = 4,
  parameter int PASSES = 3,
  parameter int IW     = 6,
  parameter int JW     = 2,
  parameter int PW     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          seed_we,
  output logic          mix_en,
  output logic          last_mix,
  output logic          ready,
  output logic [IW-1:0] idx,
  output logic [JW-1:0] jdx
);

  localparam logic [IW-1:0] I_LAST = IW'(NRK - 1);
  localparam logic [JW-1:0] J_LAST = JW'(NLW - 1);
  localparam logic [PW-1:0] P_LAST = PW'(PASSES - 1);

  ke_state_e     state_q;
  logic [IW-1:0] idx_q;
  logic [JW-1:0] jdx_q;
  logic [PW-1:0] pass_q;
  logic          i_wrap;
  logic          j_wrap;

  assign i_wrap = (idx_q == I_LAST);
  assign j_wrap = (jdx_q == J_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      jdx_q   <= '0;
      pass_q  <= '0;
    end else if (start) begin
      state_q <= ST_SEED;
      idx_q   <= '0;
      jdx_q   <= '0;
      pass_q  <= '0;
    end else begin
      case (state_q)
        ST_SEED: begin
          idx_q <= i_wrap ? '0 : idx_q + 1'b1;
          if (i_wrap) state_q <= ST_MIX;
        end
        ST_MIX: begin
          idx_q <= i_wrap ? '0 : idx_q + 1'b1;
          jdx_q <= j_wrap ? '0 : jdx_q + 1'b1;
          if (i_wrap) pass_q <= pass_q + 1'b1;
          if (last_mix) state_q <= ST_DONE;
        end
        default: ;
      endcase
    end
  end

  assign seed_we  = (state_q == ST_SEED);
  assign mix_en   = (state_q == ST_MIX);
  assign last_mix = mix_en && i_wrap && (pass_q == P_LAST);
  assign ready    = (state_q == ST_DONE);
  assign idx      = idx_q;
  assign jdx      = jdx_q;

  p_ready_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ready);

  p_ready_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(last_mix) && !$past(start)));

  p_pass_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mix_en |-> (pass_q <= P_LAST));

  p_ready_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start) |=> ready);

  generate
    if (NRK % NLW == 0) begin : g_jtrack
      p_key_idx_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mix_en |-> (32'(jdx_q) == (32'(idx_q) % NLW)));
    end
  endgenerate

endmodule

// File: rtl/rc6ke_table.sv
module rc6ke_table
  import rc6ke_pkg::*;
#(
  parameter int NRK = 44,
  parameter int IW  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  word_t         wdata,
  input  logic [IW-1:0] mix_raddr,
  output word_t         mix_rdata,
  input  logic [IW-1:0] rd_addr,
  output word_t         rd_data
);

  localparam logic [IW-1:0] A_LAST = IW'(NRK - 1);

  word_t tab [NRK];

  generate
    for (genvar e = 0; e < NRK; e++) begin : g_entry
      always_ff @(posedge clk) begin
        if (we && (waddr == IW'(e))) tab[e] <= wdata;
      end
    end
  endgenerate

  assign mix_rdata = (mix_raddr <= A_LAST) ? tab[mix_raddr] : '0;
  assign rd_data   = (rd_addr   <= A_LAST) ? tab[rd_addr]   : '0;

  p_waddr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (waddr <= A_LAST));

  p_mix_raddr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (mix_raddr == waddr));

endmodule

// File: rtl/rc6ke_mix.sv
module rc6ke_mix
  import rc6ke_pkg::*;
#(
  parameter int NLW = 4,
  parameter int JW  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_key,
  input  logic [NLW*WORD_W-1:0] key,
  input  logic                  seed_we,
  input  logic                  mix_en,
  input  logic [JW-1:0]         jdx,
  input  word_t                 s_rd,
  output logic                  wr_en,
  output word_t                 wr_data
);

  word_t l_q [NLW];
  word_t x_q;
  word_t y_q;
  word_t seed_q;
  word_t x_new;
  word_t y_new;
  word_t l_sel;

  assign l_sel = l_q[jdx];
  assign x_new = mix_tab(s_rd, x_q, y_q);
  assign y_new = mix_key(l_sel, x_new, y_q);

  generate
    for (genvar k = 0; k < NLW; k++) begin : g_kw
      always_ff @(posedge clk) begin
        if (!rst_n)                           l_q[k] <= '0;
        else if (load_key)                    l_q[k] <= key[k*WORD_W +: WORD_W];
        else if (mix_en && (jdx == JW'(k)))   l_q[k] <= y_new;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || load_key) begin
      x_q    <= '0;
      y_q    <= '0;
      seed_q <= SEED_BASE;
    end else begin
      if (seed_we) seed_q <= seed_q + SEED_STEP;
      if (mix_en) begin
        x_q <= x_new;
        y_q <= y_new;
      end
    end
  end

  assign wr_en   = seed_we || mix_en;
  assign wr_data = seed_we ? seed_q : x_new;

  p_seed_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_we && !load_key && $past(seed_we) && !$past(load_key))
      |-> (wr_data == $past(wr_data) + SEED_STEP));

  p_phase_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(seed_we && mix_en));

endmodule

// File: rtl/rc6_keyexp.sv
module rc6_keyexp
  import rc6ke_pkg::*;
#(
  parameter int ROUNDS    = 20,
  parameter int KEY_WORDS = 4,
  parameter int PASSES    = 3,
  parameter int NRK       = 2 * ROUNDS + 4,
  parameter int AW        = $clog2(NRK)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [KEY_WORDS*WORD_W-1:0] user_key,
  input  logic [AW-1:0]               rk_addr,
  output logic [WORD_W-1:0]           rk_data,
  output logic                        ready
);

  localparam int JW = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1;
  localparam int PW = (PASSES > 1) ? $clog2(PASSES) : 1;

  logic          seed_we;
  logic          mix_en;
  logic          last_mix;
  logic [AW-1:0] idx;
  logic [JW-1:0] jdx;
  logic          wr_en;
  word_t         wr_data;
  word_t         s_rd;

  rc6ke_ctrl #(
    .NRK(NRK), .NLW(KEY_WORDS), .PASSES(PASSES), .IW(AW), .JW(JW), .PW(PW)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .seed_we(seed_we), .mix_en(mix_en), .last_mix(last_mix),
    .ready(ready), .idx(idx), .jdx(jdx)
  );

  rc6ke_mix #(
    .NLW(KEY_WORDS), .JW(JW)
  ) mix_i (
    .clk(clk), .rst_n(rst_n), .load_key(start), .key(user_key),
    .seed_we(seed_we), .mix_en(mix_en), .jdx(jdx), .s_rd(s_rd),
    .wr_en(wr_en), .wr_data(wr_data)
  );

  rc6ke_table #(
    .NRK(NRK), .IW(AW)
  ) table_i (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(idx), .wdata(wr_data),
    .mix_raddr(idx), .mix_rdata(s_rd), .rd_addr(rk_addr), .rd_data(rk_data)
  );

  p_no_write_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !ready);

  p_last_then_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (last_mix && !start) |=> ready);

endmodule

// File: tb/rc6_keyexp_tb_top.sv
module rc6_keyexp_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] user_key = '0;
  logic [5:0]   rk_addr = '0;
  logic [31:0]  rk_data;
  logic         ready;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_s [44];

  always #4 clk = ~clk;

  rc6_keyexp dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .user_key(user_key),
    .rk_addr(rk_addr), .rk_data(rk_data), .ready(ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rl(input logic [31:0] v, input int s);
    logic [63:0] d;
    d = {v, v} << (s % 32);
    return d[63:32];
  endfunction

  task automatic ref_expand(input logic [127:0] k);
    logic [31:0] lw [4];
    logic [31:0] x;
    logic [31:0] y;
    int t;
    int kk;
    for (int n = 0; n < 4; n++) lw[n] = k[32*n +: 32];
    for (int n = 0; n < 44; n++) exp_s[n] = 32'hB7E15163 + 32'(n) * 32'h9E3779B9;
    x = 0; y = 0; t = 0; kk = 0;
    for (int it = 0; it < 132; it++) begin
      x = rl(exp_s[t] + x + y, 3);
      y = rl(lw[kk] + x + y, int'((x + y) & 32'h1f));
      exp_s[t] = x;
      lw[kk] = y;
      t = (t + 1) % 44;
      kk = (kk + 1) % 4;
    end
  endtask

  // pulse start with key k; returns at negedge after the sampling edge
  task automatic kick(input logic [127:0] k);
    @(negedge clk);
    user_key = k;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  // count edges until ready; optionally scramble key input meanwhile (R10)
  task automatic wait_ready(input bit scramble, output int edges);
    edges = 0;
    while (!ready && edges < 400) begin
      if (scramble) user_key = {user_key[126:0], user_key[127]} ^ 128'h5A5A;
      @(posedge clk);
      @(negedge clk);
      edges++;
    end
  endtask

  task automatic check_table(input string req);
    for (int a = 0; a < 44; a++) begin
      rk_addr = 6'(a);
      #1;
      chk(req, rk_data, exp_s[a]);
    end
  endtask

  task automatic full_run(input logic [127:0] k, input bit scramble);
    int e;
    ref_expand(k);
    kick(k);
    chk("R2 ready low after start", 32'(ready), 32'd0);
    wait_ready(scramble, e);
    chk("R3 edges to ready", 32'(e), 32'd176);
    check_table(scramble ? "R10 R4 R5 R6 R7 table" : "R4 R5 R6 R7 table");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int e;
    logic [127:0] k;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ready in reset", 32'(ready), 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 ready idle after reset", 32'(ready), 32'd0);

    full_run('0, 1'b0);
    full_run({128{1'b1}}, 1'b0);
    for (int b = 0; b < 16; b++) k[8*b +: 8] = 8'(b);
    full_run(k, 1'b0);
    // R4: single byte at the top of the key only
    full_run(128'h80 << 120, 1'b0);
    for (int n = 1; n <= 6; n++) begin
      for (int w = 0; w < 4; w++)
        k[32*w +: 32] = 32'(n) * 32'h01234567 + 32'(w) * 32'h89ABCDEF;
      full_run(k, n[0]);
    end

    // R7: out-of-range addresses read zero
    for (int a = 44; a < 64; a++) begin
      rk_addr = 6'(a);
      #1;
      chk("R7 out of range reads zero", rk_data, 32'd0);
    end

    // R9: key input changes while ready
    @(negedge clk);
    user_key = 128'hDEADBEEF_00000000_FFFFFFFF_12345678;
    repeat (6) @(negedge clk);
    chk("R9 ready held", 32'(ready), 32'd1);
    check_table("R9 table unchanged");

    // R8: restart collides with the final mixing step
    k = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;
    kick(128'h11111111_22222222_33333333_44444444);
    e = 0;
    while (e < 175) begin
      @(posedge clk);
      @(negedge clk);
      e++;
    end
    user_key = k;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk("R8 ready low on collision edge", 32'(ready), 32'd0);
    ref_expand(k);
    wait_ready(1'b0, e);
    chk("R8 edges after collision restart", 32'(e), 32'd176);
    check_table("R8 collision table");

    // R8: restart in mid-seeding and mid-mixing
    for (int p = 0; p < 2; p++) begin
      kick(128'hAAAA5555_0000FFFF_13579BDF_2468ACE0);
      repeat (p == 0 ? 10 : 90) @(negedge clk);
      chk("R8 still busy before restart", 32'(ready), 32'd0);
      k = 128'h00112233_44556677_8899AABB_CCDDEEFF ^ 128'(p);
      ref_expand(k);
      kick(k);
      wait_ready(1'b0, e);
      chk("R8 edges after mid restart", 32'(e), 32'd176);
      check_table("R8 mid restart table");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule